// File: doc/BRIEF.md
# Multi-Slot PCM Audio Serial Port

The port moves audio samples between a host and an external codec over a four-wire serial link. The link has a bit clock, a frame sync, one data line in each direction, and transmit and receive run in every frame at the same time. As master, the port divides the system clock to make the bit clock and generates the frame sync. As slave, it follows a bit clock and sync from outside. An output-enable tells the pad ring which way the clock and sync pins point.

A frame holds up to four time slots. Each slot has its own enable, its own width (8 or 16 bits) and its own start bit within the frame. On the host side each slot has a parallel transmit word and a parallel receive word. The receive word comes with a one-cycle valid strobe. A slot's transmit word is copied into a holding register when the slot's first bit goes out, so the host may change it once the slot has started. The frame sync is either a one-bit pulse ahead of bit 0 or a level held over the first 8 or 16 bits.

Top module: `pcm_slot_port`

## Requirements
- R1: With `master_i`=1, `pcm_ctl_oe_o` is 1 and `pcm_clk_o` is a square wave whose period is 2*`half_div_i` system clock cycles.
- R2: In short-sync mode (`long_sync_i`=0), the master's frame sync is high for exactly one bit period: the last bit period of the frame, which comes just before bit 0.
- R3: In long-sync mode (`long_sync_i`=1), the master's frame sync is high for bits 0 to 7 when `long_sync_w16_i`=0, and for bits 0 to 15 when it is 1. It is low for every other bit.
- R4: A master frame lasts `frame_last_i`+1 bit periods. Bit 0 follows the sync as described in R2 and R3.
- R5: Slot n covers bits start..start+w-1. Its start is `slot_start_i[8n+7:8n]`, and w is 16 when `slot_w16_i[n]`=1, otherwise 8. Within the slot the output sends `tx_data_i[16n+w-1:16n]` MSB first. The output changes only when the bit clock rises.
- R6: The output is low in every bit period that belongs to no enabled slot. A disabled slot never raises its valid strobe and leaves its receive word unchanged.
- R7: Input bits are sampled on the falling bit-clock edge. When an enabled slot's last bit has been captured, `rx_data_o[16n+15:16n]` holds the word, MSB first. An 8-bit word is zero-extended. `rx_valid_o[n]` is high for that one system cycle, once per frame.
- R8: When start+w exceeds the frame length, the slot is cut off at the frame end and its valid strobe never fires.
- R9: With `master_i`=0, `pcm_ctl_oe_o`, `pcm_clk_o` and `pcm_sync_o` stay low. The port receives on an external bit clock of at most a quarter of the system clock. It aligns its frame to an external short sync.
- R10: During reset, all outputs except `pcm_ctl_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate bit clock and sync, 0: follow external ones |
| long_sync_i | input | 1 | 1: long frame sync, 0: short pulse |
| long_sync_w16_i | input | 1 | Long sync width: 1 gives 16 bits, 0 gives 8 bits |
| half_div_i | input | DIV_W | System cycles per bit-clock half period (master) |
| frame_last_i | input | 8 | Frame length minus one, 7 to 255 |
| slot_en_i | input | NUM_SLOTS | Per-slot enable |
| slot_w16_i | input | NUM_SLOTS | Per-slot width: 1 gives 16 bits, 0 gives 8 bits |
| slot_start_i | input | NUM_SLOTS*8 | Per-slot start bit |
| tx_data_i | input | NUM_SLOTS*16 | Per-slot transmit words |
| rx_data_o | output | NUM_SLOTS*16 | Per-slot received words |
| rx_valid_o | output | NUM_SLOTS | Per-slot receive strobe |
| pcm_clk_i | input | 1 | External bit clock (slave) |
| pcm_sync_i | input | 1 | External frame sync (slave) |
| pcm_din_i | input | 1 | Serial data in |
| pcm_clk_o | output | 1 | Generated bit clock (master) |
| pcm_sync_o | output | 1 | Generated frame sync (master) |
| pcm_ctl_oe_o | output | 1 | Output enable for clock and sync pins |
| pcm_dout_o | output | 1 | Serial data out |

## Verification
On every cycle, the assertions check the following:
- In master mode, the data output and the frame sync move only on a rising bit clock.
- A short sync never stays high across two bit periods.
- Receive strobes last one cycle, line up with a falling bit clock and come only from enabled slots.
- A slave drives neither clock nor sync.

Some behaviour only the bench scenarios can show:
- Bit order, slot placement and gaps.
- The frame length and the width of the long sync.
- Cut-off slots, and locking a slave to an external short sync.

The bench shows these by looping the data line back in master mode and by driving frames into the slave.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned SLOT_CNT  = 4;
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned BITIDX_W  = 8;
endpackage

// File: rtl/pcm_bit_timing.sv
module pcm_bit_timing #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             ext_clk_i,
  input  logic             ext_sync_i,
  input  logic             ext_din_i,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sync_o,
  output logic             din_o
);
  logic [DIV_W-1:0] cnt_q, half_m1;
  logic             mclk_q, tick, ck_d;
  logic [1:0]       ck_s, sy_s, dn_s;

  assign half_m1 = (half_i == '0) ? '0 : half_i - 1'b1;
  assign tick    = cnt_q >= half_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mclk_q <= 1'b0;
      ck_s   <= '0;
      sy_s   <= '0;
      dn_s   <= '0;
      ck_d   <= 1'b0;
    end else begin
      ck_s <= {ck_s[0], ext_clk_i};
      sy_s <= {sy_s[0], ext_sync_i};
      dn_s <= {dn_s[0], ext_din_i};
      ck_d <= ck_s[1];
      if (master_i) begin
        if (tick) begin
          cnt_q  <= '0;
          mclk_q <= ~mclk_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q  <= '0;
        mclk_q <= 1'b0;
      end
    end
  end

  assign bclk_o = mclk_q;
  assign rise_o = master_i ? (tick & ~mclk_q) : (ck_s[1] & ~ck_d);
  assign fall_o = master_i ? (tick & mclk_q)  : (~ck_s[1] & ck_d);
  assign sync_o = sy_s[1];
  // master: codec data is launched by our own clock, sample directly
  assign din_o  = master_i ? ext_din_i : dn_s[1];
endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             long_sync_i,
  input  logic             long_sync_w16_i,
  input  logic [CNT_W-1:0] frame_last_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             ext_sync_i,
  output logic [CNT_W-1:0] cur_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             lock_o,
  output logic             lock_n_o,
  output logic             sync_o
);
  localparam int unsigned W1 = CNT_W + 1;

  logic [CNT_W-1:0] bit_q, pend_val_q;
  logic             lock_q, pend_q, sprev_q, sync_q, wrap, sync_n, hit;

  assign wrap     = bit_q >= frame_last_i;
  assign lock_n_o = lock_q | (master_i ? wrap : pend_q);
  assign nxt_o    = (!master_i && pend_q) ? pend_val_q
                  : (wrap ? '0 : bit_q + 1'b1);
  assign sync_n   = master_i & lock_n_o &
                    (long_sync_i ? ({1'b0, nxt_o} < (long_sync_w16_i ? W1'(16) : W1'(8)))
                                 : (nxt_o == frame_last_i));
  // slave alignment: short pulse marks the bit before 0, long level rises on bit 0
  assign hit      = long_sync_i ? (ext_sync_i & ~sprev_q) : ext_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q      <= '1;
      pend_val_q <= '0;
      lock_q     <= 1'b0;
      pend_q     <= 1'b0;
      sprev_q    <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      if (rise_i) begin
        bit_q  <= nxt_o;
        lock_q <= lock_n_o;
        pend_q <= 1'b0;
        sync_q <= sync_n;
      end
      if (fall_i && !master_i) begin
        sprev_q <= ext_sync_i;
        if (hit) begin
          pend_q     <= 1'b1;
          pend_val_q <= long_sync_i ? CNT_W'(1) : '0;
        end
      end
    end
  end

  assign cur_o  = bit_q;
  assign lock_o = lock_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/pcm_slot_lane.sv
module pcm_slot_lane #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             lock_i,
  input  logic             lock_n_i,
  input  logic             en_i,
  input  logic             w16_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] cur_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [SW-1:0]    tx_i,
  input  logic             din_i,
  output logic             bit_o,
  output logic [SW-1:0]    rx_o,
  output logic             valid_o
);
  localparam int unsigned OFF_W = CNT_W + 1;
  localparam int unsigned HW    = SW / 2;

  logic [OFF_W-1:0] width, off_n, off_c;
  logic             act_n, act_c, first_n, last_c, got_q, valid_q;
  logic [SW-1:0]    hold_q, sh_q, src, rx_q;
  logic [3:0]       idx;

  assign width   = w16_i ? OFF_W'(SW) : OFF_W'(HW);
  assign off_n   = {1'b0, nxt_i} - {1'b0, start_i};
  assign off_c   = {1'b0, cur_i} - {1'b0, start_i};
  assign act_n   = en_i & lock_n_i & (nxt_i >= start_i) & (off_n < width);
  assign act_c   = en_i & lock_i & (cur_i >= start_i) & (off_c < width);
  assign first_n = off_n == '0;
  assign last_c  = off_c == width - 1'b1;
  assign src     = first_n ? tx_i : hold_q;
  assign idx     = w16_i ? (4'd15 - off_n[3:0]) : {1'b0, 3'd7 - off_n[2:0]};
  assign bit_o   = act_n & src[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      got_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (rise_i && act_n && first_n) hold_q <= tx_i;
      if (fall_i && act_c) begin
        sh_q <= {sh_q[SW-2:0], din_i};
        if (off_c == '0) got_q <= 1'b1;
        if (last_c) begin
          got_q   <= 1'b0;
          valid_q <= got_q;
          if (got_q) rx_q <= w16_i ? {sh_q[SW-2:0], din_i}
                                   : {{HW{1'b0}}, sh_q[HW-2:0], din_i};
        end
      end
    end
  end

  assign rx_o    = rx_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = SLOT_CNT,
  parameter int unsigned DIV_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          master_i,
  input  logic                          long_sync_i,
  input  logic                          long_sync_w16_i,
  input  logic [DIV_W-1:0]              half_div_i,
  input  logic [BITIDX_W-1:0]           frame_last_i,
  input  logic [NUM_SLOTS-1:0]          slot_en_i,
  input  logic [NUM_SLOTS-1:0]          slot_w16_i,
  input  logic [NUM_SLOTS*BITIDX_W-1:0] slot_start_i,
  input  logic [NUM_SLOTS*SAMPLE_W-1:0] tx_data_i,
  output logic [NUM_SLOTS*SAMPLE_W-1:0] rx_data_o,
  output logic [NUM_SLOTS-1:0]          rx_valid_o,
  input  logic                          pcm_clk_i,
  input  logic                          pcm_sync_i,
  input  logic                          pcm_din_i,
  output logic                          pcm_clk_o,
  output logic                          pcm_sync_o,
  output logic                          pcm_ctl_oe_o,
  output logic                          pcm_dout_o
);
  localparam int unsigned CNT_W = BITIDX_W;
  localparam int unsigned SW    = SAMPLE_W;

  logic             rise, fall, ext_sync, din;
  logic [CNT_W-1:0] cur, nxt;
  logic             lock, lock_n, dout_q;
  logic [NUM_SLOTS-1:0] bit_vec;

  pcm_bit_timing #(.DIV_W(DIV_W)) u_timing (
    .clk_i, .rst_ni, .master_i,
    .half_i     (half_div_i),
    .ext_clk_i  (pcm_clk_i),
    .ext_sync_i (pcm_sync_i),
    .ext_din_i  (pcm_din_i),
    .bclk_o     (pcm_clk_o),
    .rise_o     (rise),
    .fall_o     (fall),
    .sync_o     (ext_sync),
    .din_o      (din)
  );

  pcm_frame_ctl #(.CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .master_i, .long_sync_i, .long_sync_w16_i, .frame_last_i,
    .rise_i     (rise),
    .fall_i     (fall),
    .ext_sync_i (ext_sync),
    .cur_o      (cur),
    .nxt_o      (nxt),
    .lock_o     (lock),
    .lock_n_o   (lock_n),
    .sync_o     (pcm_sync_o)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_lane
    pcm_slot_lane #(.CNT_W(CNT_W), .SW(SW)) u_lane (
      .clk_i, .rst_ni,
      .rise_i   (rise),
      .fall_i   (fall),
      .lock_i   (lock),
      .lock_n_i (lock_n),
      .en_i     (slot_en_i[s]),
      .w16_i    (slot_w16_i[s]),
      .start_i  (slot_start_i[s*CNT_W +: CNT_W]),
      .cur_i    (cur),
      .nxt_i    (nxt),
      .tx_i     (tx_data_i[s*SW +: SW]),
      .din_i    (din),
      .bit_o    (bit_vec[s]),
      .rx_o     (rx_data_o[s*SW +: SW]),
      .valid_o  (rx_valid_o[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= 1'b0;
    else if (rise) dout_q <= |bit_vec;
  end

  assign pcm_dout_o   = dout_q;
  assign pcm_ctl_oe_o = master_i;
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 master_i,
  input logic                 long_sync_i,
  input logic [NUM_SLOTS-1:0] slot_en_i,
  input logic [NUM_SLOTS-1:0] rx_valid_o,
  input logic                 pcm_clk_o,
  input logic                 pcm_sync_o,
  input logic                 pcm_dout_o
);
  AST_DOUT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && !$stable(pcm_dout_o) |-> $rose(pcm_clk_o)); // R5
  AST_SYNC_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && !$stable(pcm_sync_o) |-> $rose(pcm_clk_o)); // R3
  AST_SHORT_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && !long_sync_i && $rose(pcm_clk_o) && $past(pcm_sync_o) |-> !pcm_sync_o); // R2
  AST_VALID_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && (|rx_valid_o) |-> $fell(pcm_clk_o)); // R7
  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i && !$rose(master_i) |-> !pcm_clk_o && !pcm_sync_o); // R9

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_s
    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o[s] |=> !rx_valid_o[s]); // R7
    AST_VALID_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o[s] |-> slot_en_i[s]); // R6
  end
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_i    (master_i),
  .long_sync_i (long_sync_i),
  .slot_en_i   (slot_en_i),
  .rx_valid_o  (rx_valid_o),
  .pcm_clk_o   (pcm_clk_o),
  .pcm_sync_o  (pcm_sync_o),
  .pcm_dout_o  (pcm_dout_o)
);

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
  localparam int NS = 4;

  typedef struct packed {
    logic        long_s;
    logic        l16;
    logic [7:0]  half;
    logic [7:0]  last;
    logic [3:0]  en;
    logic [3:0]  w16;
    logic [31:0] starts;
    logic [63:0] tx;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd2, 8'd31,  4'b0111, 4'b0010, {8'd10, 8'd24, 8'd8, 8'd0},
      {16'hFFFF, 16'h00A5, 16'hBEEF, 16'h1234}},
    '{1'b1, 1'b0, 8'd1, 8'd63,  4'b1111, 4'b1111, {8'd48, 8'd32, 8'd16, 8'd0},
      {16'h8001, 16'h7FFE, 16'hC3C3, 16'h5A5A}},
    '{1'b1, 1'b1, 8'd3, 8'd39,  4'b1001, 4'b1000, {8'd30, 8'd5, 8'd5, 8'd3},
      {16'hA5F0, 16'h1111, 16'h2222, 16'h00C7}},
    '{1'b0, 1'b0, 8'd2, 8'd7,   4'b0001, 4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},
      {16'h0000, 16'h0000, 16'h0000, 16'h0096}},
    '{1'b0, 1'b0, 8'd4, 8'd255, 4'b1010, 4'b1010, {8'd240, 8'd0, 8'd100, 8'd0},
      {16'hFEDC, 16'h4444, 16'h1357, 16'h6666}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1, long_s = 1'b0, l16 = 1'b0;
  logic [7:0] half = 8'd2, last = 8'd31;
  logic [3:0] en = '0, w16 = '0;
  logic [31:0] starts = '0;
  logic [63:0] tx = '0;
  logic [63:0] rx_data;
  logic [3:0]  rx_valid;
  logic ext_clk = 1'b0, ext_sync = 1'b0, slv_din = 1'b0;
  logic pcm_din, pcm_clk_o, pcm_sync_o, pcm_oe, pcm_dout;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;
  int sv_cnt [NS];
  logic [15:0] sv_dat [NS];

  always #10 clk = ~clk;

  assign pcm_din = master ? pcm_dout : slv_din;

  pcm_slot_port dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .long_sync_i(long_s),
    .long_sync_w16_i(l16), .half_div_i(half), .frame_last_i(last),
    .slot_en_i(en), .slot_w16_i(w16), .slot_start_i(starts), .tx_data_i(tx),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .pcm_clk_i(ext_clk), .pcm_sync_i(ext_sync), .pcm_din_i(pcm_din),
    .pcm_clk_o(pcm_clk_o), .pcm_sync_o(pcm_sync_o), .pcm_ctl_oe_o(pcm_oe),
    .pcm_dout_o(pcm_dout)
  );

  always @(negedge clk) begin
    if (mon_on)
      for (int s = 0; s < NS; s++)
        if (rx_valid[s]) begin
          sv_cnt[s]++;
          sv_dat[s] = rx_data[s*16 +: 16];
        end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic exp_bit(vec_t v, int b);
    for (int s = 0; s < NS; s++) begin
      int st = int'(v.starts[s*8 +: 8]);
      int w  = v.w16[s] ? 16 : 8;
      if (v.en[s] && b >= st && b < st + w) return v.tx[s*16 + (w - 1 - (b - st))];
    end
    return 1'b0;
  endfunction

  function automatic logic exp_sync(vec_t v, int b);
    if (v.long_s) return b < (v.l16 ? 16 : 8);
    return b == int'(v.last);
  endfunction

  task automatic run_vec(input vec_t v);
    int bcnt = -1, frames = -1, len_seen = 0, dmis = 0, smis = 0;
    int vcnt [NS];
    logic [15:0] vdat [NS];
    logic pclk = 1'b0, psync = 1'b0, sh_next = 1'b0, new0;
    master = 1'b1; long_s = v.long_s; l16 = v.l16; half = v.half; last = v.last;
    en = v.en; w16 = v.w16; starts = v.starts; tx = v.tx;
    for (int s = 0; s < NS; s++) begin vcnt[s] = 0; vdat[s] = '0; end
    do_reset();
    while (frames < 2) begin
      @(negedge clk);
      if (frames == 1)
        for (int s = 0; s < NS; s++)
          if (rx_valid[s]) begin vcnt[s]++; vdat[s] = rx_data[s*16 +: 16]; end
      if (pclk && !pcm_clk_o) begin
        new0 = v.long_s ? (pcm_sync_o && !psync) : sh_next;
        sh_next = pcm_sync_o;
        psync = pcm_sync_o;
        if (new0) begin
          frames++;
          if (frames == 2) len_seen = bcnt + 1;
          bcnt = 0;
        end else if (bcnt >= 0) bcnt++;
        if (frames == 1) begin
          if (pcm_dout !== exp_bit(v, bcnt)) dmis++;
          if (pcm_sync_o !== exp_sync(v, bcnt)) smis++;
        end
      end
      pclk = pcm_clk_o;
    end
    if (v.long_s) check(smis == 0, "R3 long sync bits", smis, 0);
    else          check(smis == 0, "R2 short sync bits", smis, 0);
    check(len_seen == int'(v.last) + 1, "R4 frame length", len_seen, int'(v.last) + 1);
    check(dmis == 0, "R5 R6 serial out bits", dmis, 0);
    for (int s = 0; s < NS; s++) begin
      int st = int'(v.starts[s*8 +: 8]);
      int w  = v.w16[s] ? 16 : 8;
      logic [15:0] ed = v.w16[s] ? v.tx[s*16 +: 16] : {8'h00, v.tx[s*16 +: 8]};
      if (!v.en[s])
        check(vcnt[s] == 0 && rx_data[s*16 +: 16] == 16'h0, "R6 disabled slot", vcnt[s], 0);
      else if (st + w > int'(v.last) + 1)
        check(vcnt[s] == 0 && rx_data[s*16 +: 16] == 16'h0, "R8 truncated slot", vcnt[s], 0);
      else
        check(vcnt[s] == 1 && vdat[s] == ed, "R7 slot receive", {vcnt[s], vdat[s]}, {32'd1, ed});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t0, t1;
    // R10 reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(pcm_clk_o == 0 && pcm_sync_o == 0 && pcm_dout == 0 && rx_valid == 0 && rx_data == '0,
          "R10 reset outputs", {pcm_clk_o, pcm_sync_o, pcm_dout, rx_valid}, 0);

    // stimulus table walk, master loopback
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1 clock divider and pin direction
    master = 1'b1; half = 8'd3; en = '0;
    do_reset();
    @(negedge clk);
    while (!(pcm_clk_o === 1'b1)) @(negedge clk);
    while (!(pcm_clk_o === 1'b0)) @(negedge clk);
    t0 = 0;
    while (!(pcm_clk_o === 1'b1)) begin @(negedge clk); t0++; end
    t1 = 0;
    while (!(pcm_clk_o === 1'b0)) begin @(negedge clk); t1++; end
    check(t0 + t1 == 6, "R1 bit clock period", t0 + t1, 6);
    check(pcm_oe == 1'b1, "R1 master drives pins", pcm_oe, 1);

    // R9 slave receive with external clock and short sync
    master = 1'b0; long_s = 1'b0; last = 8'd15; en = 4'b0011; w16 = 4'b0000;
    starts = {8'd0, 8'd0, 8'd8, 8'd0}; tx = '0;
    do_reset();
    for (int s = 0; s < NS; s++) begin sv_cnt[s] = 0; sv_dat[s] = '0; end
    mon_on = 1'b1;
    for (int f = 0; f < 3; f++)
      for (int b = 0; b < 16; b++) begin
        logic [15:0] pat = 16'hC53A;
        ext_clk = 1'b1; slv_din = pat[15 - b]; ext_sync = (b == 15);
        repeat (6) @(negedge clk);
        ext_clk = 1'b0;
        repeat (6) @(negedge clk);
      end
    repeat (20) @(negedge clk);
    mon_on = 1'b0;
    check(sv_cnt[0] == 2 && sv_dat[0] == 16'h00C5, "R9 slave slot0 receive", {sv_cnt[0], sv_dat[0]}, {32'd2, 16'h00C5});
    check(sv_cnt[1] == 2 && sv_dat[1] == 16'h003A, "R9 slave slot1 receive", {sv_cnt[1], sv_dat[1]}, {32'd2, 16'h003A});
    check(pcm_oe == 0 && pcm_clk_o == 0 && pcm_sync_o == 0, "R9 slave pins quiet",
          {pcm_oe, pcm_clk_o, pcm_sync_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule